// File: doc/BRIEF.md
# Accumulator Arithmetic-Logic Unit with Condition Flags

This block computes the next accumulator byte for an 8-bit processor datapath and keeps the five condition flags in its own register. In each cycle the caller presents an accumulator value, a second operand byte and an operation code. The block returns the result byte and the flag set that the operation would produce. The carry and auxiliary-carry inputs of an operation come from the block's own flag register. When the flag write enable is high, the next rising clock edge copies the proposed flag set into that register.

The operation set covers binary add and subtract, each with and without the carry or borrow chained in. It also covers compare, three bitwise operations, four single-bit rotates, the complement and carry-control operations, and a decimal correction step that turns the byte left by a binary add of two packed BCD values back into packed BCD. A separate 16-bit adder joins two register-pair values. It reports only its overflow, through the carry flag. Instruction decode, operand fetch and the register file belong to the surrounding datapath.

Top module: `acc_alu`

## Requirements
- R1: `flags_o` holds sign in bit 4, zero in bit 3, auxiliary carry in bit 2, parity in bit 1 and carry in bit 0. Reset clears all five. The parity bit is 1 when the byte it describes has an even number of one bits. Sign is bit 7 of that byte and zero means that the byte is 0x00.
- R2: `flags_o` takes the value of `flags_nxt_o` on a rising clock edge only while `flag_we_i` is 1. Otherwise it keeps its value.
- R3: Add (code 0) and add-with-carry (code 1, which adds the carry flag as well) give the sum modulo 256. Carry is the carry out of bit 7 and auxiliary carry is the carry out of bit 3. Sign, zero and parity describe the result.
- R4: Subtract (code 2) and subtract-with-borrow (code 3, which also subtracts the carry flag) give the difference modulo 256. Carry is 1 when a borrow leaves bit 7. Auxiliary carry is 1 when the low nibble needs a borrow from bit 4. Sign, zero and parity describe the difference.
- R5: Compare (code 4) returns the accumulator unchanged. Its flags are those of a plain subtract, so carry is set when accumulator < operand and zero is set when they are equal.
- R6: AND (code 5) returns the bitwise AND, sets auxiliary carry, clears carry, and sets sign, zero and parity from the result.
- R7: XOR (code 6) and OR (code 7) return their bitwise result, clear both carry and auxiliary carry, and set sign, zero and parity from the result.
- R8: Code 8 rotates left with bit 7 going to bit 0 and to carry. Code 9 rotates right with bit 0 going to bit 7 and to carry. Code 10 rotates left through carry: the old carry goes to bit 0 and bit 7 goes to carry. Code 11 rotates right through carry: the old carry goes to bit 7 and bit 0 goes to carry. None of them alters sign, zero, parity or auxiliary carry.
- R9: Code 12 returns the inverted accumulator and leaves all flags as they are. Code 13 inverts only carry and code 14 sets only carry. Both return the accumulator unchanged.
- R10: Decimal adjust (code 15) first adds 6 when the low nibble is above 9 or auxiliary carry is set. It then adds 0x60 when the upper nibble of that sum is above 9, the sum passed 0xFF, or carry is set. The new carry is 1 exactly when the second correction is applied. The new auxiliary carry is the carry out of bit 3 from the first correction. Sign, zero and parity describe the final byte.
- R11: Pair add (code 16) drives `pair_sum_o` with `pair_a_i + pair_b_i` modulo 65536 and sets carry to the overflow past bit 15. It leaves the other four flags alone and returns the accumulator unchanged.
- R12: Codes 17 to 31 return the accumulator unchanged and propose the current flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 5 | Operation code |
| acc_i | input | 8 | Accumulator value |
| opnd_i | input | 8 | Second operand byte |
| pair_a_i | input | PAIR_W | First register-pair value for the pair add |
| pair_b_i | input | PAIR_W | Second register-pair value for the pair add |
| flag_we_i | input | 1 | Flag register write enable |
| result_o | output | 8 | Result byte |
| pair_sum_o | output | PAIR_W | Register-pair sum |
| flags_nxt_o | output | 5 | Proposed flag set |
| flags_o | output | 5 | Registered flag set |

## Verification
Two actions can fall on the same edge: the flag register takes a new carry or auxiliary carry, and the next operation reads that flag as its chained input. The bench provokes this with back-to-back add-with-carry, subtract-with-borrow, rotate-through-carry and decimal-adjust steps, interleaved with cycles where the write enable is low. A reference model in the bench advances its own flag state with each step. Each cycle, the bench compares the result and proposed flags just before the edge, and the registered flags just after it.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  localparam int DW    = 8;
  localparam int NIB   = DW / 2;
  localparam int FLW   = 5;
  localparam int OPW   = 5;

  localparam int F_CY = 0;
  localparam int F_P  = 1;
  localparam int F_AC = 2;
  localparam int F_Z  = 3;
  localparam int F_S  = 4;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 5'd0,
    OP_ADC  = 5'd1,
    OP_SUB  = 5'd2,
    OP_SBB  = 5'd3,
    OP_CMP  = 5'd4,
    OP_AND  = 5'd5,
    OP_XOR  = 5'd6,
    OP_OR   = 5'd7,
    OP_RLC  = 5'd8,
    OP_RRC  = 5'd9,
    OP_RAL  = 5'd10,
    OP_RAR  = 5'd11,
    OP_CMA  = 5'd12,
    OP_CMC  = 5'd13,
    OP_STC  = 5'd14,
    OP_DAA  = 5'd15,
    OP_PADD = 5'd16
  } op_e;

  typedef struct packed {
    logic [DW-1:0] r;
    logic          c_hi;
    logic          c_lo;
  } arith_t;

  function automatic arith_t add8(input logic [DW-1:0] a, input logic [DW-1:0] b,
                                  input logic cin);
    arith_t          o;
    logic [DW:0]     full;
    logic [NIB:0]    low;
    full   = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
    low    = {1'b0, a[NIB-1:0]} + {1'b0, b[NIB-1:0]} + {{NIB{1'b0}}, cin};
    o.r    = full[DW-1:0];
    o.c_hi = full[DW];
    o.c_lo = low[NIB];
    return o;
  endfunction

  function automatic arith_t sub8(input logic [DW-1:0] a, input logic [DW-1:0] b,
                                  input logic bin);
    arith_t          o;
    logic [DW:0]     full;
    logic [NIB:0]    low;
    full   = {1'b0, a} - {1'b0, b} - {{DW{1'b0}}, bin};
    low    = {1'b0, a[NIB-1:0]} - {1'b0, b[NIB-1:0]} - {{NIB{1'b0}}, bin};
    o.r    = full[DW-1:0];
    o.c_hi = full[DW];
    o.c_lo = low[NIB];
    return o;
  endfunction

  function automatic arith_t dec_adjust(input logic [DW-1:0] a, input logic cy,
                                        input logic ac);
    arith_t       o;
    logic         lo_fix;
    logic         hi_fix;
    logic [DW:0]  t;
    logic [NIB:0] lo_sum;
    lo_fix = (a[NIB-1:0] > 4'd9) || ac;
    lo_sum = {1'b0, a[NIB-1:0]} + (lo_fix ? 5'd6 : 5'd0);
    t      = {1'b0, a} + (lo_fix ? 9'd6 : 9'd0);
    hi_fix = (t[DW-1:NIB] > 4'd9) || t[DW] || cy;
    o.r    = t[DW-1:0] + (hi_fix ? 8'h60 : 8'h00);
    o.c_hi = hi_fix;
    o.c_lo = lo_sum[NIB];
    return o;
  endfunction

  function automatic logic [FLW-1:0] mk_flags(input logic [DW-1:0] r, input logic ac,
                                              input logic cy);
    logic [FLW-1:0] f;
    f[F_S]  = r[DW-1];
    f[F_Z]  = (r == '0);
    f[F_AC] = ac;
    f[F_P]  = ~^r;
    f[F_CY] = cy;
    return f;
  endfunction

endpackage

// File: rtl/acc_alu_arith.sv
module acc_alu_arith
  import acc_alu_pkg::*;
#(
  parameter int PAIR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  op_e               op,
  input  logic [DW-1:0]     a,
  input  logic [DW-1:0]     b,
  input  logic              cy_in,
  input  logic [PAIR_W-1:0] pa,
  input  logic [PAIR_W-1:0] pb,
  output logic [DW-1:0]     res,
  output logic              cy_out,
  output logic              ac_out,
  output logic [PAIR_W-1:0] pair_sum,
  output logic              pair_cy
);

  logic   is_add;
  logic   is_sub;
  logic   chain_in;
  arith_t sum_w;
  arith_t dif_w;

  assign is_add   = (op == OP_ADD) || (op == OP_ADC);
  assign is_sub   = (op == OP_SUB) || (op == OP_SBB) || (op == OP_CMP);
  assign chain_in = ((op == OP_ADC) || (op == OP_SBB)) && cy_in;

  always_comb begin
    sum_w = add8(a, b, chain_in);
    dif_w = sub8(a, b, chain_in);
    if (is_sub) begin
      res    = dif_w.r;
      cy_out = dif_w.c_hi;
      ac_out = dif_w.c_lo;
    end else begin
      res    = sum_w.r;
      cy_out = sum_w.c_hi;
      ac_out = sum_w.c_lo;
    end
  end

  always_comb begin
    logic [PAIR_W:0] wide;
    wide     = {1'b0, pa} + {1'b0, pb};
    pair_sum = wide[PAIR_W-1:0];
    pair_cy  = wide[PAIR_W];
  end

  // R3: a carry out of an add can never leave a result above the accumulator
  a_r3_wrap_below: assert property (@(posedge clk) disable iff (!rst_n)
    (is_add && cy_out) |-> (res <= a));

  // R4: a plain subtract borrows exactly when the minuend is smaller
  a_r4_borrow_order: assert property (@(posedge clk) disable iff (!rst_n)
    ((op == OP_SUB) || (op == OP_CMP)) |-> (cy_out == (a < b)));

  // R11: pair overflow means the sum wrapped below an addend
  a_r11_pair_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    pair_cy |-> (pair_sum < pa));

endmodule

// File: rtl/acc_alu_bitops.sv
module acc_alu_bitops
  import acc_alu_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  op_e           op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cy_in,
  output logic [DW-1:0] res,
  output logic          cy_out
);

  logic is_rot;
  assign is_rot = (op == OP_RLC) || (op == OP_RRC) || (op == OP_RAL) || (op == OP_RAR);

  always_comb begin
    res    = a;
    cy_out = cy_in;
    unique case (op)
      OP_AND: begin res = a & b; cy_out = 1'b0; end
      OP_XOR: begin res = a ^ b; cy_out = 1'b0; end
      OP_OR:  begin res = a | b; cy_out = 1'b0; end
      OP_RLC: begin res = {a[DW-2:0], a[DW-1]}; cy_out = a[DW-1]; end
      OP_RRC: begin res = {a[0], a[DW-1:1]};    cy_out = a[0];    end
      OP_RAL: begin res = {a[DW-2:0], cy_in};   cy_out = a[DW-1]; end
      OP_RAR: begin res = {cy_in, a[DW-1:1]};   cy_out = a[0];    end
      OP_CMA: res = ~a;
      OP_CMC: cy_out = ~cy_in;
      OP_STC: cy_out = 1'b1;
      default: ;
    endcase
  end

  // R8: a rotate keeps the population count of the byte
  a_r8_rot_popcount: assert property (@(posedge clk) disable iff (!rst_n)
    ((op == OP_RLC) || (op == OP_RRC)) |-> ($countones(res) == $countones(a)));

  // R8: every rotate pushes an end bit of the accumulator into carry
  a_r8_rot_carry_src: assert property (@(posedge clk) disable iff (!rst_n)
    is_rot |-> ((cy_out == a[DW-1]) || (cy_out == a[0])));

endmodule

// File: rtl/acc_alu_daa.sv
module acc_alu_daa
  import acc_alu_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic [DW-1:0] a,
  input  logic          cy_in,
  input  logic          ac_in,
  output logic [DW-1:0] res,
  output logic          cy_out,
  output logic          ac_out
);

  arith_t adj_w;

  always_comb begin
    adj_w  = dec_adjust(a, cy_in, ac_in);
    res    = adj_w.r;
    cy_out = adj_w.c_hi;
    ac_out = adj_w.c_lo;
  end

  // R10: an incoming carry is never lost by the adjustment
  a_r10_carry_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cy_in) |-> cy_out);

  // R10: a valid BCD byte with no pending carries passes unchanged
  a_r10_bcd_identity: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !cy_in && !ac_in && (a[3:0] <= 4'd9) && (a[7:4] <= 4'd9))
      |-> (res == a && !cy_out));

endmodule

// File: rtl/acc_alu_flagreg.sv
module acc_alu_flagreg
  import acc_alu_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [FLW-1:0] nxt,
  output logic [FLW-1:0] flags
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  flags <= '0;
    else if (we) flags <= nxt;
  end

  // R2: disabled write keeps the register
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> (flags == $past(flags)));

  // R2: enabled write captures the proposal
  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (flags == $past(nxt)));

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int PAIR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OPW-1:0]    op_i,
  input  logic [DW-1:0]     acc_i,
  input  logic [DW-1:0]     opnd_i,
  input  logic [PAIR_W-1:0] pair_a_i,
  input  logic [PAIR_W-1:0] pair_b_i,
  input  logic              flag_we_i,
  output logic [DW-1:0]     result_o,
  output logic [PAIR_W-1:0] pair_sum_o,
  output logic [FLW-1:0]    flags_nxt_o,
  output logic [FLW-1:0]    flags_o
);

  op_e           op;
  logic [DW-1:0] ar_res, bo_res, da_res;
  logic          ar_cy, ar_ac, bo_cy, da_cy, da_ac, pr_cy;
  logic          is_arith, is_rot, is_daa, is_undef;

  assign op       = op_e'(op_i);
  assign is_arith = (op_i <= 5'd4);
  assign is_rot   = (op == OP_RLC) || (op == OP_RRC) || (op == OP_RAL) || (op == OP_RAR);
  assign is_daa   = (op == OP_DAA);
  assign is_undef = (op_i > 5'd16);

  acc_alu_arith #(.PAIR_W(PAIR_W)) u_arith (
    .clk(clk), .rst_n(rst_n), .op(op), .a(acc_i), .b(opnd_i),
    .cy_in(flags_o[F_CY]), .pa(pair_a_i), .pb(pair_b_i),
    .res(ar_res), .cy_out(ar_cy), .ac_out(ar_ac),
    .pair_sum(pair_sum_o), .pair_cy(pr_cy)
  );

  acc_alu_bitops u_bitops (
    .clk(clk), .rst_n(rst_n), .op(op), .a(acc_i), .b(opnd_i),
    .cy_in(flags_o[F_CY]), .res(bo_res), .cy_out(bo_cy)
  );

  acc_alu_daa u_daa (
    .clk(clk), .rst_n(rst_n), .active(is_daa), .a(acc_i),
    .cy_in(flags_o[F_CY]), .ac_in(flags_o[F_AC]),
    .res(da_res), .cy_out(da_cy), .ac_out(da_ac)
  );

  acc_alu_flagreg u_flags (
    .clk(clk), .rst_n(rst_n), .we(flag_we_i), .nxt(flags_nxt_o), .flags(flags_o)
  );

  always_comb begin
    result_o    = acc_i;
    flags_nxt_o = flags_o;
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
        result_o    = ar_res;
        flags_nxt_o = mk_flags(ar_res, ar_ac, ar_cy);
      end
      OP_CMP:  flags_nxt_o = mk_flags(ar_res, ar_ac, ar_cy);
      OP_AND: begin
        result_o    = bo_res;
        flags_nxt_o = mk_flags(bo_res, 1'b1, bo_cy);
      end
      OP_XOR, OP_OR: begin
        result_o    = bo_res;
        flags_nxt_o = mk_flags(bo_res, 1'b0, bo_cy);
      end
      OP_RLC, OP_RRC, OP_RAL, OP_RAR: begin
        result_o           = bo_res;
        flags_nxt_o[F_CY]  = bo_cy;
      end
      OP_CMA:  result_o = bo_res;
      OP_CMC, OP_STC: flags_nxt_o[F_CY] = bo_cy;
      OP_DAA: begin
        result_o    = da_res;
        flags_nxt_o = mk_flags(da_res, da_ac, da_cy);
      end
      OP_PADD: flags_nxt_o[F_CY] = pr_cy;
      default: ;
    endcase
  end

  // R5: compare never disturbs the accumulator
  a_r5_cmp_keeps_acc: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_CMP) |-> (result_o == acc_i));

  // R5: equal operands give zero and no borrow
  a_r5_cmp_equal: assert property (@(posedge clk) disable iff (!rst_n)
    ((op == OP_CMP) && (acc_i == opnd_i)) |-> (flags_nxt_o[F_Z] && !flags_nxt_o[F_CY]));

  // R6: AND forces the two carry flags
  a_r6_and_carries: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_AND) |-> (!flags_nxt_o[F_CY] && flags_nxt_o[F_AC]));

  // R7: XOR and OR clear both carries
  a_r7_logic_carries: assert property (@(posedge clk) disable iff (!rst_n)
    ((op == OP_XOR) || (op == OP_OR)) |-> (flags_nxt_o[F_CY] == 1'b0 && flags_nxt_o[F_AC] == 1'b0));

  // R8: rotates touch only the carry flag
  a_r8_rot_flags: assert property (@(posedge clk) disable iff (!rst_n)
    is_rot |-> (flags_nxt_o[FLW-1:1] == flags_o[FLW-1:1]));

  // R9: complementing the accumulator leaves every flag
  a_r9_cma_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_CMA) |-> (flags_nxt_o == flags_o));

  // R9: carry control leaves the accumulator
  a_r9_carry_ctl_acc: assert property (@(posedge clk) disable iff (!rst_n)
    ((op == OP_CMC) || (op == OP_STC)) |-> (result_o == acc_i));

  // R11: pair add touches only carry
  a_r11_pair_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_PADD) |-> (flags_nxt_o[FLW-1:1] == flags_o[FLW-1:1] && result_o == acc_i));

  // R12: unused codes are inert
  a_r12_undef_inert: assert property (@(posedge clk) disable iff (!rst_n)
    is_undef |-> (flags_nxt_o == flags_o && result_o == acc_i));

  // R3: arithmetic results agree with the zero flag they propose
  a_r3_zero_match: assert property (@(posedge clk) disable iff (!rst_n)
    (is_arith && op != OP_CMP) |-> (flags_nxt_o[F_Z] == (result_o == 8'h00)));

endmodule

// File: tb/acc_alu_test.sv
module acc_alu_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  op_i = '0;
  logic [7:0]  acc_i = '0;
  logic [7:0]  opnd_i = '0;
  logic [15:0] pair_a_i = '0;
  logic [15:0] pair_b_i = '0;
  logic        flag_we_i = 1'b0;
  logic [7:0]  result_o;
  logic [15:0] pair_sum_o;
  logic [4:0]  flags_nxt_o;
  logic [4:0]  flags_o;

  int checks = 0;
  int fails  = 0;
  int model_flags = 0;
  bit done = 0;

  always #10 clk = ~clk;

  acc_alu uut (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .acc_i(acc_i), .opnd_i(opnd_i),
    .pair_a_i(pair_a_i), .pair_b_i(pair_b_i), .flag_we_i(flag_we_i),
    .result_o(result_o), .pair_sum_o(pair_sum_o),
    .flags_nxt_o(flags_nxt_o), .flags_o(flags_o)
  );

  function automatic string tag_of(input int op);
    case (op)
      0, 1:          return "R3";
      2, 3:          return "R4";
      4:             return "R5";
      5:             return "R6";
      6, 7:          return "R7";
      8, 9, 10, 11:  return "R8";
      12, 13, 14:    return "R9";
      15:            return "R10";
      16:            return "R11";
      default:       return "R12";
    endcase
  endfunction

  function automatic int pack_flags(input int r, input int ac, input int cy);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += (r >> i) & 1;
    return ((r >= 128) << 4) | ((r == 0) << 3) | (ac << 2) | (((ones % 2) == 0) << 1) | cy;
  endfunction

  task automatic ref_model(input int op, input int a, input int b, input int pa,
                           input int pb, input int f, output int r, output int nf,
                           output int ps);
    int cy = f & 1;
    int ac = (f >> 2) & 1;
    int c, d, t, lo, fix;
    bit hi;
    r  = a;
    nf = f;
    ps = (pa + pb) % 65536;
    case (op)
      0, 1: begin
        c  = (op == 1) ? cy : 0;
        t  = a + b + c;
        r  = t % 256;
        nf = pack_flags(r, ((a % 16) + (b % 16) + c) > 15, t > 255);
      end
      2, 3, 4: begin
        c  = (op == 3) ? cy : 0;
        d  = a - b - c;
        t  = (d + 256) % 256;
        nf = pack_flags(t, ((a % 16) - (b % 16) - c) < 0, d < 0);
        r  = (op == 4) ? a : t;
      end
      5: begin r = a & b; nf = pack_flags(r, 1, 0); end
      6: begin r = a ^ b; nf = pack_flags(r, 0, 0); end
      7: begin r = a | b; nf = pack_flags(r, 0, 0); end
      8:  begin r = (a * 2) % 256 + a / 128; nf = (f & ~1) | (a / 128); end
      9:  begin r = a / 2 + (a % 2) * 128;   nf = (f & ~1) | (a % 2); end
      10: begin r = (a * 2) % 256 + cy;      nf = (f & ~1) | (a / 128); end
      11: begin r = a / 2 + cy * 128;        nf = (f & ~1) | (a % 2); end
      12: r = 255 - a;
      13: nf = f ^ 1;
      14: nf = f | 1;
      15: begin
        lo  = a % 16;
        fix = (lo > 9 || ac == 1) ? 6 : 0;
        t   = a + fix;
        hi  = (((t / 16) % 16) > 9) || (t > 255) || (cy == 1);
        if (hi) t += 96;
        r   = t % 256;
        nf  = pack_flags(r, (lo + fix) > 15, hi);
      end
      16: nf = (f & ~1) | ((pa + pb) > 65535);
      default: ;
    endcase
  endtask

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input int op, input int a, input int b, input bit we,
                      input int pa = 0, input int pb = 0);
    int r, nf, ps;
    @(negedge clk);
    check("R2", "registered flags", int'(flags_o), model_flags);
    op_i = op[4:0]; acc_i = a[7:0]; opnd_i = b[7:0]; flag_we_i = we;
    pair_a_i = pa[15:0]; pair_b_i = pb[15:0];
    #8;
    ref_model(op, a, b, pa, pb, model_flags, r, nf, ps);
    check(tag_of(op), "result", int'(result_o), r);
    check(tag_of(op), "next flags", int'(flags_nxt_o), nf);
    if (op == 16) check("R11", "pair sum", int'(pair_sum_o), ps);
    if (we) model_flags = nf;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "reset flags", int'(flags_o), 0);
    rst_n = 1'b1;
    // R3 half carry and sign, then wrap to zero with both carries
    step(0, 8'h7F, 8'h01, 1);
    step(0, 8'hFF, 8'h01, 1);
    step(1, 8'h10, 8'h20, 1);          // R3 chained carry in
    step(2, 8'h10, 8'h01, 1);          // R4 nibble borrow
    step(2, 8'h01, 8'h02, 1);          // R4 full borrow
    step(3, 8'h05, 8'h05, 1);          // R4 borrow chained
    step(4, 8'h20, 8'h30, 1);          // R5 less
    step(4, 8'h42, 8'h42, 1);          // R5 equal
    step(4, 8'h90, 8'h10, 1);          // R5 greater
    step(5, 8'hF0, 8'h3C, 1);          // R6
    step(6, 8'h5A, 8'h5A, 1);          // R7 xor to zero
    step(7, 8'h80, 8'h01, 1);          // R7 or
    step(14, 8'h11, 8'h00, 1);         // R9 set carry
    step(10, 8'h40, 8'h00, 1);         // R8 carry into bit 0
    step(11, 8'h01, 8'h00, 1);         // R8
    step(8, 8'h81, 8'h00, 1);          // R8
    step(9, 8'h02, 8'h00, 1);          // R8
    step(13, 8'h33, 8'h00, 1);         // R9 invert carry
    step(12, 8'hA5, 8'h00, 1);         // R9 complement
    step(0, 8'h38, 8'h45, 1);          // R10 prep: 0x7D
    step(15, 8'h7D, 8'h00, 1);         // R10 -> 0x83
    step(0, 8'h99, 8'h01, 1);
    step(15, 8'h9A, 8'h00, 1);         // R10 -> 0x00 with carry
    step(0, 8'h09, 8'h09, 1);          // half carry set
    step(15, 8'h12, 8'h00, 1);         // R10 auxiliary carry path
    step(16, 8'h66, 8'h00, 1, 16'hFFFF, 16'h0002);  // R11 overflow
    step(16, 8'h66, 8'h00, 1, 16'h1234, 16'h1111);  // R11 no overflow
    step(20, 8'h77, 8'h12, 1);         // R12
    step(31, 8'h00, 8'hFF, 1);         // R12
    step(0, 8'hFF, 8'hFF, 0);          // R2 write disabled
    step(2, 8'h00, 8'h01, 0);          // R2 write disabled
    step(1, 8'h00, 8'h00, 1);          // carry still as held
    for (int i = 0; i < 400; i++)
      step($urandom_range(0, 21), $urandom_range(0, 255), $urandom_range(0, 255),
           ($urandom_range(0, 3) != 0), $urandom_range(0, 65535), $urandom_range(0, 65535));
    @(negedge clk);
    check("R2", "registered flags", int'(flags_o), model_flags);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule